// File: doc/BRIEF.md
# UART Transmit Queue with Threshold Status

This block is the sending half of a serial port. Characters written through a one-cycle write strobe are queued in a 32-entry FIFO. A shift engine takes the oldest character whenever it is idle. It wraps the character in an asynchronous frame and drives it onto the serial line. Each bit lasts sixteen periods of an oversampling tick that comes from outside the block. The frame format can be set to seven or eight data bits, one or two stop bits, and no parity, even parity or odd parity. The shift engine reads the format at the moment it starts each frame.

Three status outputs are kept apart. `tx_ready` means the queue holds fewer characters than a programmable threshold. `fifo_empty` reflects the queue alone. `drain_done` means the queue and the shifter have both finished. `ready_irq` is `tx_ready` gated by an enable input. A synchronous soft reset discards the queue and aborts any frame in flight. The threshold is stored in a register that a load strobe writes. The soft reset leaves that register alone.

Top module: `uart_tx_queue`

## Requirements
- R1: `tx_ready` is high exactly when the number of queued characters is below the threshold register. That register holds 2 after `rst_n`, and a `thr_wr` pulse loads it from `thr_data`.
- R2: `fifo_empty` is high exactly when the queue holds no character. It is high after reset.
- R3: `drain_done` is high only when the queue is empty and no frame is being shifted out. While the last frame is still on the line it stays low, even though `fifo_empty` is already high.
- R4: The line idles high. A frame is sent in this order:
  - a start bit of 0;
  - the data bits, least significant first;
  - the parity bit, if enabled;
  - one stop bit of 1, or two if `cfg_two_stop` is 1.

  Each bit lasts 16 `tick16` pulses. The line holds its level while `tick16` is low.
- R5: With `cfg_word8` = 0, seven data bits are sent and bit 7 of the written value is ignored. With `cfg_word8` = 1, all eight bits are sent.
- R6: With `cfg_par_en` = 1, a parity bit follows the data. When `cfg_par_odd` = 0 it makes the number of ones in data plus parity even. When `cfg_par_odd` = 1 it makes that count odd. With `cfg_par_en` = 0 no parity bit is sent.
- R7: The queue holds 32 characters and sends them in write order. A write while it is full is dropped. A write in the same cycle as a removal by the shifter is kept.
- R8: `ready_irq` equals `tx_ready` AND `rdy_irq_en`.
- R9: A `soft_rst` pulse empties the queue, aborts the current frame and returns `txd` high on the next cycle. The threshold register keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous clear of queue and shifter |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 8 | Character to queue |
| thr_wr | input | 1 | Load strobe for the threshold register |
| thr_data | input | 6 | New threshold value |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| cfg_word8 | input | 1 | 1: eight data bits, 0: seven |
| cfg_two_stop | input | 1 | 1: two stop bits |
| cfg_par_en | input | 1 | 1: parity bit sent |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| rdy_irq_en | input | 1 | Enable for the ready interrupt |
| txd | output | 1 | Serial output |
| tx_ready | output | 1 | Queue level below threshold |
| fifo_empty | output | 1 | Queue holds no character |
| drain_done | output | 1 | Queue and shifter both idle |
| ready_irq | output | 1 | Ready interrupt |

## Verification
A write and the shifter's removal of a character can fall in the same clock edge. The bench provokes this with a burst of back-to-back writes into an idle shifter: the second write lands on the edge where the first character is taken. It then overfills the queue with tick16 held low. The overlap is judged by the serial data that follows: exactly the first 33 values must appear, in order, with none lost or repeated. A soft reset is also made to fall while a frame is stalled mid-line. It is judged by the line and both empty flags on the next cycle.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
    // Longest frame: start + 8 data + parity + 2 stop
    localparam int FRAME_MAX = 12;
    localparam int FLEN_W    = 4;

    typedef struct packed {
        logic word8;
        logic two_stop;
        logic par_en;
        logic par_odd;
    } txq_fmt_t;
endpackage

// File: rtl/uart_txq_fifo.sv
module uart_txq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [LW-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && (st_q.lvl != '0);
        push_ok = push && (st_q.lvl != LW'(DEPTH));
        if (clr) begin
            st_d = '0;
        end else begin
            if (push_ok)
                st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
            if (pop_ok)
                st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   st_d.lvl = st_q.lvl + 1'b1;
                2'b01:   st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem_q[st_q.wp] <= din;
    end

    assign dout  = mem_q[st_q.rp];
    assign level = st_q.lvl;
endmodule

// File: rtl/uart_txq_shift.sv
module uart_txq_shift
    import uart_txq_pkg::*;
#(
    parameter int OSR = 16,
    localparam int CW = $clog2(OSR)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic       avail,
    input  logic [7:0] din,
    input  txq_fmt_t   fmt,
    output logic       pop,
    output logic       txd,
    output logic       busy
);
    typedef struct packed {
        logic                 busy;
        logic [FRAME_MAX-1:0] sh;
        logic [FLEN_W-1:0]    left;
        logic [CW-1:0]        phase;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic [FRAME_MAX-1:0] frame;
    logic [FLEN_W-1:0]    flen;
    logic [7:0]           dsel;
    logic                 par;

    // Frame assembly from the queue head and the current format
    always_comb begin
        dsel  = fmt.word8 ? din : {1'b0, din[6:0]};
        par   = fmt.par_odd ? ~(^dsel) : (^dsel);
        frame = '1;
        frame[0]   = 1'b0;
        frame[7:1] = dsel[6:0];
        if (fmt.word8) frame[8] = dsel[7];
        if (fmt.par_en) begin
            if (fmt.word8) frame[9] = par;
            else           frame[8] = par;
        end
        flen = FLEN_W'(1) + (fmt.word8 ? FLEN_W'(8) : FLEN_W'(7))
             + FLEN_W'(fmt.par_en) + (fmt.two_stop ? FLEN_W'(2) : FLEN_W'(1));
    end

    always_comb begin
        st_d = st_q;
        pop  = 1'b0;
        if (clr) begin
            st_d    = '0;
            st_d.sh = '1;
        end else if (!st_q.busy) begin
            if (avail) begin
                pop        = 1'b1;
                st_d.busy  = 1'b1;
                st_d.sh    = frame;
                st_d.left  = flen;
                st_d.phase = '0;
            end
        end else if (tick) begin
            if (st_q.phase == CW'(OSR - 1)) begin
                st_d.phase = '0;
                st_d.sh    = {1'b1, st_q.sh[FRAME_MAX-1:1]};
                st_d.left  = st_q.left - 1'b1;
                if (st_q.left == FLEN_W'(1)) st_d.busy = 1'b0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.sh <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign txd  = st_q.busy ? st_q.sh[0] : 1'b1;
    assign busy = st_q.busy;
endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue
    import uart_txq_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int OSR     = 16,
    parameter int THR_RST = 2,
    localparam int LW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          thr_wr,
    input  logic [LW-1:0] thr_data,
    input  logic          tick16,
    input  logic          cfg_word8,
    input  logic          cfg_two_stop,
    input  logic          cfg_par_en,
    input  logic          cfg_par_odd,
    input  logic          rdy_irq_en,
    output logic          txd,
    output logic          tx_ready,
    output logic          fifo_empty,
    output logic          drain_done,
    output logic          ready_irq
);
    logic [LW-1:0] thr_d, thr_q;
    logic [LW-1:0] level_w;
    logic [7:0]    head_w;
    logic          pop_w, busy_w;
    txq_fmt_t      fmt_w;

    assign fmt_w = '{word8: cfg_word8, two_stop: cfg_two_stop,
                     par_en: cfg_par_en, par_odd: cfg_par_odd};

    always_comb begin
        thr_d = thr_q;
        if (thr_wr) thr_d = thr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= LW'(THR_RST);
        else        thr_q <= thr_d;
    end

    uart_txq_fifo #(.DW(8), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .push  (wr_en),
        .din   (wr_data),
        .pop   (pop_w),
        .dout  (head_w),
        .level (level_w)
    );

    uart_txq_shift #(.OSR(OSR)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (soft_rst),
        .tick  (tick16),
        .avail (level_w != '0),
        .din   (head_w),
        .fmt   (fmt_w),
        .pop   (pop_w),
        .txd   (txd),
        .busy  (busy_w)
    );

    assign fifo_empty = (level_w == '0);
    assign tx_ready   = (level_w < thr_q);
    assign drain_done = fifo_empty && !busy_w;
    assign ready_irq  = tx_ready && rdy_irq_en;
endmodule

// File: rtl/uart_txq_chk.sv
module uart_txq_chk #(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_rst,
    input logic          wr_en,
    input logic          pop,
    input logic [LW-1:0] level,
    input logic          txd,
    input logic          tx_ready,
    input logic          fifo_empty,
    input logic          drain_done,
    input logic          ready_irq
);
    a_r3_done_needs_empty: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> fifo_empty);

    a_r4_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> txd);

    a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ready_irq |-> tx_ready);

    a_r9_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (fifo_empty && txd && drain_done));

    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LW'(DEPTH) && wr_en && !pop && !soft_rst) |=> (level == LW'(DEPTH)));

    a_r2_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !soft_rst) |=> !fifo_empty || $past(pop));
endmodule

bind uart_tx_queue uart_txq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_rst   (soft_rst),
    .wr_en      (wr_en),
    .pop        (pop_w),
    .level      (level_w),
    .txd        (txd),
    .tx_ready   (tx_ready),
    .fifo_empty (fifo_empty),
    .drain_done (drain_done),
    .ready_irq  (ready_irq)
);

// File: tb/test_uart_tx_queue.sv
module test_uart_tx_queue;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       thr_wr = 1'b0;
    logic [5:0] thr_data = '0;
    logic       tick16 = 1'b1;
    logic       cfg_word8 = 1'b1;
    logic       cfg_two_stop = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rdy_irq_en = 1'b0;
    logic       txd, tx_ready, fifo_empty, drain_done, ready_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #2 clk = ~clk;   // 250 MHz

    uart_tx_queue i_uart_tx_queue (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_data(wr_data), .thr_wr(thr_wr), .thr_data(thr_data),
        .tick16(tick16), .cfg_word8(cfg_word8), .cfg_two_stop(cfg_two_stop),
        .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rdy_irq_en(rdy_irq_en), .txd(txd), .tx_ready(tx_ready),
        .fifo_empty(fifo_empty), .drain_done(drain_done), .ready_irq(ready_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // fields: data[11:4], word8, two_stop, par_en, par_odd
    localparam logic [11:0] VEC [0:5] = '{
        {8'hA5, 4'b1000},
        {8'h3C, 4'b1110},
        {8'hD5, 4'b0011},
        {8'h81, 4'b0100},
        {8'hFF, 4'b1011},
        {8'h7E, 4'b0010}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic w8,
                                              input logic ts, input logic pe,
                                              input logic po, output int len);
        logic [11:0] f;
        int n;
        logic ones;
        f = '0; n = 1; ones = 1'b0;
        for (int k = 0; k < (w8 ? 8 : 7); k++) begin
            f[n] = d[k]; ones = ones ^ d[k]; n++;
        end
        if (pe) begin f[n] = po ? ~ones : ones; n++; end
        f[n] = 1'b1; n++;
        if (ts) begin f[n] = 1'b1; n++; end
        len = n;
        return f;
    endfunction

    task automatic capture(input int len, output logic [11:0] bits);
        bits = '0;
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
        repeat (8) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < len; i++) begin
            repeat (16) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic burst(input int n, input int base);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_data = 8'(base + i);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_soft;
        @(negedge clk); soft_rst = 1'b1;
        @(negedge clk); soft_rst = 1'b0;
    endtask

    task automatic set_thr(input logic [5:0] v);
        @(negedge clk); thr_wr = 1'b1; thr_data = v;
        @(negedge clk); thr_wr = 1'b0;
    endtask

    initial begin
        logic [11:0] got, exp;
        int len;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R4 reset txd", txd, 1);
        check("R2 reset fifo_empty", fifo_empty, 1);
        check("R3 reset drain_done", drain_done, 1);
        check("R1 reset tx_ready (0<2)", tx_ready, 1);
        check("R8 reset ready_irq", ready_irq, 0);

        // Vector table walk: frame format, word size, parity
        for (int v = 0; v < 6; v++) begin
            cfg_word8 = VEC[v][3]; cfg_two_stop = VEC[v][2];
            cfg_par_en = VEC[v][1]; cfg_par_odd = VEC[v][0];
            exp = exp_frame(VEC[v][11:4], VEC[v][3], VEC[v][2], VEC[v][1], VEC[v][0], len);
            put(VEC[v][11:4]);
            capture(len, got);
            check($sformatf("R4 R5 R6 frame vec%0d", v), got, exp);
            repeat (16) @(negedge clk);
            check($sformatf("R3 drained vec%0d", v), drain_done, 1);
        end

        // Threshold, empty and interrupt with the line stalled
        cfg_word8 = 1; cfg_two_stop = 0; cfg_par_en = 0; cfg_par_odd = 0;
        tick16 = 1'b0;
        rdy_irq_en = 1'b1;
        burst(3, 8'h10);
        check("R2 queued fifo_empty", fifo_empty, 0);
        check("R1 level 2 not below 2", tx_ready, 0);
        check("R3 not drained", drain_done, 0);
        check("R4 start bit held", txd, 0);
        check("R8 irq follows ready low", ready_irq, 0);
        set_thr(6'd3);
        @(negedge clk);
        check("R1 level 2 below 3", tx_ready, 1);
        check("R8 irq enabled", ready_irq, 1);
        rdy_irq_en = 1'b0;
        @(negedge clk);
        check("R8 irq masked", ready_irq, 0);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        check("R9 soft reset empties", fifo_empty, 1);
        check("R9 soft reset drained", drain_done, 1);
        check("R9 soft reset line idle", txd, 1);
        burst(3, 8'h20);
        check("R9 threshold kept (2<3)", tx_ready, 1);
        burst(1, 8'h30);
        check("R1 level 3 not below 3", tx_ready, 0);
        pulse_soft();
        set_thr(6'd2);

        // Overflow with back-to-back writes and a same-edge pop
        burst(40, 0);
        check("R7 full not ready", tx_ready, 0);
        tick16 = 1'b1;
        for (int f = 0; f < 33; f++) begin
            exp = exp_frame(8'(f), 1, 0, 0, 0, len);
            capture(len, got);
            check($sformatf("R7 order frame %0d", f), got, exp);
        end
        repeat (40) @(negedge clk);
        check("R7 extra writes dropped", txd, 1);
        check("R7 queue drained", drain_done, 1);

        // Drain complete waits for the shifter
        put(8'h5A);
        repeat (3) @(negedge clk);
        check("R2 empty while shifting", fifo_empty, 1);
        check("R3 not done while shifting", drain_done, 0);
        exp = exp_frame(8'h5A, 1, 0, 0, 0, len);
        capture(len, got);
        check("R4 last frame", got, exp);
        repeat (16) @(negedge clk);
        check("R3 done after shifter", drain_done, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule